// File: doc/BRIEF.md
# Scaled SVGA Single-Sprite Generator

This block generates an 800x600, 60 Hz video raster with positive horizontal and vertical sync and 6-bit colour, 2 bits for each of red, green and blue. The picture is built on a coarse 100x75 logical grid. Every logical pixel covers an 8x8 block of screen pixels. One 12x12 sprite is drawn over one of four background patterns. Each sprite pixel is a 2-bit index into a four-entry palette of 6-bit colours. Index 0 is transparent.

The sprite bitmap, the palette, the background choice and the sprite position are loaded through a write-only serial port. This port is sampled with the pixel clock. Position writes are held and only move to the active position at the boundary between two lines, and they are clamped so the whole sprite stays on screen. The current sprite row is held in a shift register that advances only while the beam is inside the sprite. A mode input lets the block run from a 10 MHz clock instead of 40 MHz: each clock then covers four screen pixels.

Top module: `sprite_video_gen`

## Requirements
- R1: With `slow_pix` low, one line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks (1056 by default) and one frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (628). `hsync` is high for H_SYNC pixels starting at pixel H_ACTIVE+H_FP. `vsync` is high for V_SYNC lines starting at line V_ACTIVE+V_FP.
- R2: Outside the active area, {red,green,blue} is 6'b000000.
- R3: Register 0x38 bits [1:0] select the background, with logical coordinates lx = h/8 and ly = v/8. The codes are: 0 black; 1 solid palette entry 0; 2 palette entry 0 where lx is odd and black elsewhere; 3 palette entry 0 where lx+ly is odd and black elsewhere.
- R4: The sprite covers logical columns X..X+11 and logical rows Y..Y+11. Each sprite pixel spans 8x8 screen pixels. A non-zero 2-bit index shows palette entry `index` (rrggbb). Index 0 lets the background show.
- R5: A write frame is 16 bits sent MSB first while `spi_cs_n` is low, sampled on rising `spi_sclk`: an 8-bit address followed by 8 data bits. If chip select rises before the 16th bit, the frame is dropped.
- R6: The register map is as follows.
  - Bytes 0x00..0x23 hold the bitmap. Row r uses bytes 3r..3r+2. Each byte holds four pixels, leftmost in bits [7:6].
  - 0x30..0x33 hold palette entries 0..3 in data[5:0].
  - 0x39 holds the X position request and 0x3A holds the Y position request.
- R7: A position request moves to the active position only at the end of the last clock of a line. A line already being drawn keeps the old position.
- R8: A position request is clamped: X to at most 100-12 and Y to at most 75-12 (in general, logical width or height minus 12).
- R9: With `slow_pix` high, each clock advances four screen pixels. A line then lasts a quarter of the clocks, and the sync widths are scaled the same way.
- R10: The outputs are registered: screen pixel n of a frame appears on the clock after the counter reaches it. While `rst` is high, every output is low and all registers clear. After reset the raster restarts at pixel (0,0).
- R11: A write to an address outside the map changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (40 MHz, or 10 MHz with slow_pix) |
| rst | input | 1 | Synchronous active-high reset |
| slow_pix | input | 1 | 1: each clock covers four screen pixels |
| spi_sclk | input | 1 | Serial write clock |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_mosi | input | 1 | Serial write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| red | output | 2 | Red level |
| green | output | 2 | Green level |
| blue | output | 2 | Blue level |

## Verification
The bench samples the edges of each sprite pixel: the last screen pixel before the sprite and the first and last of its first logical pixel. A wrong latency or scale factor would move colour by one screen pixel or widen it. A position write is made in the middle of a drawn line and checked on that line and on the next. A design that applies the write at once would clip the line in progress. Out-of-range positions are written to show that an unclamped design pushes the sprite off screen. A chip-select abort halfway through a frame is followed by a good frame, which a receiver that does not reset its bit count would misalign.

// File: rtl/svga_sprite_pkg.sv
package svga_sprite_pkg;

  typedef logic [5:0] colour_t;

  typedef enum logic [1:0] {
    BG_BLACK  = 2'd0,
    BG_SOLID  = 2'd1,
    BG_STRIPE = 2'd2,
    BG_CHECK  = 2'd3
  } bg_mode_t;

  localparam logic [7:0] ADDR_PAL  = 8'h30;
  localparam logic [7:0] ADDR_BG   = 8'h38;
  localparam logic [7:0] ADDR_POSX = 8'h39;
  localparam logic [7:0] ADDR_POSY = 8'h3A;

  localparam int SLOW_STEP = 4;

endpackage

// File: rtl/svga_raster_timing.sv
module svga_raster_timing #(
  parameter int H_ACTIVE = 800,
  parameter int H_FP     = 40,
  parameter int H_SYNC   = 128,
  parameter int H_BP     = 88,
  parameter int V_ACTIVE = 600,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 4,
  parameter int V_BP     = 23,
  localparam int HT      = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int VT      = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(HT + 1),
  localparam int VW      = $clog2(VT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slow_pix,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic [VW-1:0] vcnt_next,
  output logic          line_end,
  output logic          active_c,
  output logic          hsync_c,
  output logic          vsync_c
);
  import svga_sprite_pkg::*;

  logic [HW-1:0] step;

  always_comb begin
    step      = slow_pix ? HW'(SLOW_STEP) : HW'(1);
    line_end  = (hcnt >= HW'(HT) - step);
    vcnt_next = (vcnt == VW'(VT - 1)) ? '0 : vcnt + VW'(1);
    active_c  = (hcnt < HW'(H_ACTIVE)) && (vcnt < VW'(V_ACTIVE));
    hsync_c   = (hcnt >= HW'(H_ACTIVE + H_FP)) && (hcnt < HW'(H_ACTIVE + H_FP + H_SYNC));
    vsync_c   = (vcnt >= VW'(V_ACTIVE + V_FP)) && (vcnt < VW'(V_ACTIVE + V_FP + V_SYNC));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= vcnt_next;
    end else begin
      hcnt <= hcnt + step;
    end
  end

  a_r1_line_wraps: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (hcnt == '0));
  a_r1_line_count_holds: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(vcnt));
  a_r1_counter_range: assert property (@(posedge clk) disable iff (rst)
    (hcnt < HW'(HT)) && (vcnt < VW'(VT)));

endmodule

// File: rtl/sprite_serial_rx.sv
module sprite_serial_rx #(
  parameter int FRAME_BITS = 16,
  localparam int CW        = $clog2(FRAME_BITS)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);

  logic [1:0]            sclk_sync, cs_sync, mosi_sync;
  logic                  sclk_prev;
  logic [CW-1:0]         bit_cnt;
  logic [FRAME_BITS-2:0] shreg;
  logic                  sclk_rise;

  assign sclk_rise = sclk_sync[1] && !sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sync <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
      sclk_prev <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      sclk_sync <= {sclk_sync[0], spi_sclk};
      cs_sync   <= {cs_sync[0], spi_cs_n};
      mosi_sync <= {mosi_sync[0], spi_mosi};
      sclk_prev <= sclk_sync[1];
      wr_en     <= 1'b0;
      if (cs_sync[1]) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        if (bit_cnt == CW'(FRAME_BITS - 1)) begin
          bit_cnt <= '0;
          wr_en   <= 1'b1;
          {wr_addr, wr_data} <= {shreg, mosi_sync[1]};
        end else begin
          bit_cnt <= bit_cnt + CW'(1);
          shreg   <= {shreg[FRAME_BITS-3:0], mosi_sync[1]};
        end
      end
    end
  end

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  a_r5_abort_clears_count: assert property (@(posedge clk) disable iff (rst)
    cs_sync[1] |=> (bit_cnt == '0));

endmodule

// File: rtl/sprite_cfg_regs.sv
module sprite_cfg_regs #(
  parameter int SPR_N  = 12,
  parameter int POS_W  = 8,
  localparam int RW    = $clog2(SPR_N),
  localparam int BPR   = (2 * SPR_N) / 8,
  localparam int NBYTE = SPR_N * BPR,
  localparam int BAW   = $clog2(NBYTE)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [7:0]             wr_addr,
  input  logic [7:0]             wr_data,
  input  logic [RW-1:0]          rd_row,
  output logic [2*SPR_N-1:0]     rd_bits,
  output logic [23:0]            pal_flat,
  output svga_sprite_pkg::bg_mode_t bg_mode,
  output logic [POS_W-1:0]       pos_x_req,
  output logic [POS_W-1:0]       pos_y_req
);
  import svga_sprite_pkg::*;

  logic [7:0] bmp [NBYTE];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTE; i++) bmp[i] <= '0;
      pal_flat  <= '0;
      bg_mode   <= BG_BLACK;
      pos_x_req <= '0;
      pos_y_req <= '0;
    end else if (wr_en) begin
      if (int'(wr_addr) < NBYTE) bmp[wr_addr[BAW-1:0]] <= wr_data;
      if (wr_addr[7:2] == ADDR_PAL[7:2]) pal_flat[6*wr_addr[1:0] +: 6] <= wr_data[5:0];
      if (wr_addr == ADDR_BG) bg_mode <= bg_mode_t'(wr_data[1:0]);
      if (wr_addr == ADDR_POSX) pos_x_req <= POS_W'(wr_data);
      if (wr_addr == ADDR_POSY) pos_y_req <= POS_W'(wr_data);
    end
  end

  for (genvar k = 0; k < BPR; k++) begin : g_row_lane
    assign rd_bits[2*SPR_N-1-8*k -: 8] = bmp[BAW'(int'(rd_row) * BPR + k)];
  end

  a_r11_bg_own_addr_only: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == ADDR_BG)) |=> $stable(bg_mode));
  a_r11_pos_own_addr_only: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == ADDR_POSX)) |=> $stable(pos_x_req));

endmodule

// File: rtl/sprite_video_gen.sv
module sprite_video_gen #(
  parameter int H_ACTIVE   = 800,
  parameter int H_FP       = 40,
  parameter int H_SYNC     = 128,
  parameter int H_BP       = 88,
  parameter int V_ACTIVE   = 600,
  parameter int V_FP       = 1,
  parameter int V_SYNC     = 4,
  parameter int V_BP       = 23,
  parameter int SCALE_LOG2 = 3,
  parameter int SPR_N      = 12,
  parameter int POS_W      = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slow_pix,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       hsync,
  output logic       vsync,
  output logic [1:0] red,
  output logic [1:0] green,
  output logic [1:0] blue
);
  import svga_sprite_pkg::*;

  localparam int HT    = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int VT    = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(HT + 1);
  localparam int VW    = $clog2(VT + 1);
  localparam int LOG_W = H_ACTIVE >> SCALE_LOG2;
  localparam int LOG_H = V_ACTIVE >> SCALE_LOG2;
  localparam int X_MAX = LOG_W - SPR_N;
  localparam int Y_MAX = LOG_H - SPR_N;
  localparam int RW    = $clog2(SPR_N);
  localparam int SRW   = 2 * SPR_N;

  logic [HW-1:0]    hcnt;
  logic [VW-1:0]    vcnt, vcnt_next;
  logic             line_end, active_c, hsync_c, vsync_c;
  logic             wr_en;
  logic [7:0]       wr_addr, wr_data;
  logic [RW-1:0]    rd_row;
  logic [SRW-1:0]   rd_bits;
  logic [23:0]      pal_flat;
  bg_mode_t         bg_mode;
  logic [POS_W-1:0] pos_x_req, pos_y_req;

  svga_raster_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst(rst), .slow_pix(slow_pix),
    .hcnt(hcnt), .vcnt(vcnt), .vcnt_next(vcnt_next), .line_end(line_end),
    .active_c(active_c), .hsync_c(hsync_c), .vsync_c(vsync_c)
  );

  sprite_serial_rx #(.FRAME_BITS(16)) u_rx (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  sprite_cfg_regs #(.SPR_N(SPR_N), .POS_W(POS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_row(rd_row), .rd_bits(rd_bits), .pal_flat(pal_flat), .bg_mode(bg_mode),
    .pos_x_req(pos_x_req), .pos_y_req(pos_y_req)
  );

  function automatic logic [POS_W-1:0] clamp_pos(input logic [POS_W-1:0] v, input int lim);
    return (int'(v) > lim) ? POS_W'(lim) : v;
  endfunction

  logic [POS_W-1:0] act_x, act_y, next_x, next_y;
  logic [SRW-1:0]   spr_sh;
  logic             row_hit, in_win, sub_last, shift_en;
  logic [1:0]       pix_idx;
  int               lx, ly, ly_next;
  colour_t          bg_rgb, pix_rgb, rgb_q;

  always_comb begin
    next_x   = clamp_pos(pos_x_req, X_MAX);
    next_y   = clamp_pos(pos_y_req, Y_MAX);
    lx       = int'(hcnt >> SCALE_LOG2);
    ly       = int'(vcnt >> SCALE_LOG2);
    ly_next  = int'(vcnt_next >> SCALE_LOG2);
    row_hit  = (ly_next >= int'(next_y)) && (ly_next < int'(next_y) + SPR_N);
    rd_row   = RW'(ly_next - int'(next_y));
    in_win   = active_c && (lx >= int'(act_x)) && (lx < int'(act_x) + SPR_N);
    sub_last = slow_pix ? ((hcnt[SCALE_LOG2-1:0] | SCALE_LOG2'(SLOW_STEP - 1)) == '1)
                        : (hcnt[SCALE_LOG2-1:0] == '1);
    shift_en = in_win && sub_last;
    pix_idx  = in_win ? spr_sh[SRW-1 -: 2] : 2'b00;
    case (bg_mode)
      BG_SOLID:  bg_rgb = pal_flat[5:0];
      BG_STRIPE: bg_rgb = (lx % 2 == 1) ? pal_flat[5:0] : '0;
      BG_CHECK:  bg_rgb = ((lx + ly) % 2 == 1) ? pal_flat[5:0] : '0;
      default:   bg_rgb = '0;
    endcase
    pix_rgb  = (pix_idx != 2'b00) ? pal_flat[6*pix_idx +: 6] : bg_rgb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_x  <= '0;
      act_y  <= '0;
      spr_sh <= '0;
    end else if (line_end) begin
      act_x  <= next_x;
      act_y  <= next_y;
      spr_sh <= row_hit ? rd_bits : '0;
    end else if (shift_en) begin
      spr_sh <= {spr_sh[SRW-3:0], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_q <= '0;
      hsync <= 1'b0;
      vsync <= 1'b0;
    end else begin
      rgb_q <= active_c ? pix_rgb : '0;
      hsync <= hsync_c;
      vsync <= vsync_c;
    end
  end

  assign {red, green, blue} = rgb_q;

  a_r8_pos_clamped: assert property (@(posedge clk) disable iff (rst)
    (int'(act_x) <= X_MAX) && (int'(act_y) <= Y_MAX));
  a_r7_pos_line_only: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> ($stable(act_x) && $stable(act_y)));
  a_r4_shift_gated: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !line_end) |=> $stable(spr_sh));
  a_r2_blank_black: assert property (@(posedge clk) disable iff (rst)
    !active_c |=> (rgb_q == '0));
  a_r1_sync_in_blank: assert property (@(posedge clk) disable iff (rst)
    hsync_c |=> !$past(active_c));
  a_r3_black_bg: assert property (@(posedge clk) disable iff (rst)
    (active_c && !in_win && (bg_mode == BG_BLACK)) |=> (rgb_q == '0));

endmodule

// File: tb/sprite_video_gen_test.sv
module sprite_video_gen_test;

  localparam int HA = 128, HF = 4, HS = 8, HB = 4;
  localparam int VA = 96, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FRAME = HT * VT;
  localparam int NVEC = 24;

  // {bg code, screen h, screen v, expected rrggbb}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd0, 8'd11,  8'd3,  6'h00}, {2'd0, 8'd15,  8'd3,  6'h00},
    {2'd0, 8'd16,  8'd3,  6'h30}, {2'd0, 8'd23,  8'd3,  6'h30},
    {2'd0, 8'd24,  8'd3,  6'h0C}, {2'd0, 8'd35,  8'd3,  6'h03},
    {2'd0, 8'd43,  8'd3,  6'h00}, {2'd0, 8'd99,  8'd3,  6'h03},
    {2'd0, 8'd107, 8'd91, 6'h03},
    {2'd1, 8'd43,  8'd3,  6'h15}, {2'd1, 8'd115, 8'd43, 6'h15},
    {2'd1, 8'd130, 8'd43, 6'h00}, {2'd1, 8'd107, 8'd91, 6'h03},
    {2'd2, 8'd11,  8'd3,  6'h15}, {2'd2, 8'd51,  8'd3,  6'h00},
    {2'd2, 8'd115, 8'd43, 6'h00}, {2'd2, 8'd123, 8'd43, 6'h15},
    {2'd3, 8'd35,  8'd3,  6'h03}, {2'd3, 8'd3,   8'd11, 6'h15},
    {2'd3, 8'd19,  8'd11, 6'h15}, {2'd3, 8'd51,  8'd19, 6'h00},
    {2'd3, 8'd3,   8'd97, 6'h00}, {2'd3, 8'd11,  8'd19, 6'h15},
    {2'd3, 8'd11,  8'd27, 6'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_pix = 1'b0;
  logic spi_sclk = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic hsync, vsync;
  logic [1:0] red, green, blue;
  int pos = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sprite_video_gen #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) uut (
    .clk(clk), .rst(rst), .slow_pix(slow_pix), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .hsync(hsync), .vsync(vsync),
    .red(red), .green(green), .blue(blue)
  );

  always_ff @(posedge clk) pos <= rst ? 0 : pos + 1;

  function automatic int rgb();
    return int'({red, green, blue});
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic wait_pix(input int h, input int v);
    int n;
    n = v * HT + h;
    do @(negedge clk); while (pos < 1 || ((pos - 1) % FRAME) != n);
  endtask

  task automatic spi_send(input logic [7:0] a, input logic [7:0] d, input int nbits);
    logic [15:0] fr;
    fr = {a, d};
    spi_cs_n = 1'b0;
    for (int i = 15; i > 15 - nbits; i--) begin
      spi_mosi = fr[i];
      repeat (2) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (2) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    spi_send(a, d, 16);
  endtask

  task automatic pix_check(input int h, input int v, input int exp, input string req);
    wait_pix(h, v);
    check(rgb() == exp, req, rgb(), exp);
  endtask

  task automatic sync_check(input int h, input int v, input bit hs, input bit vs);
    wait_pix(h, v);
    check(hsync == hs, "R1 hsync", int'(hsync), int'(hs));
    check(vsync == vs, "R1 vsync", int'(vsync), int'(vs));
  endtask

  task automatic reset_pulse();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(hsync == 1'b0 && vsync == 1'b0 && rgb() == 0, "R10 outputs low in reset",
          int'({hsync, vsync, red, green, blue}), 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got hung expected done");
    finish_up();
  end

  initial begin
    int cur_bg;
    int n;
    repeat (4) @(negedge clk);
    check(hsync == 1'b0 && vsync == 1'b0 && rgb() == 0, "R10 reset state",
          int'({hsync, vsync, red, green, blue}), 0);
    rst = 1'b0;

    // R6 map: palette, bitmap bytes, background, position
    wr(8'h30, 8'h15); wr(8'h31, 8'h30); wr(8'h32, 8'h0C); wr(8'h33, 8'h03);
    wr(8'h00, 8'h6C); wr(8'h02, 8'h0C); wr(8'h23, 8'h03);
    wr(8'h38, 8'h00); wr(8'h39, 8'h02); wr(8'h3A, 8'h00);
    cur_bg = 0;

    // Table walk: R3 backgrounds, R4 sprite pixels, R2 blanking, R10 latency
    for (int i = 0; i < NVEC; i++) begin
      if (int'(VEC[i][23:22]) != cur_bg) begin
        cur_bg = int'(VEC[i][23:22]);
        wr(8'h38, 8'(cur_bg));
      end
      pix_check(int'(VEC[i][21:14]), int'(VEC[i][13:6]), int'(VEC[i][5:0]), "R3/R4/R2 vector");
    end

    // R7: position write lands mid-line; current line keeps X=2, next uses X=4
    wr(8'h38, 8'h00);
    wait_pix(0, 2);
    wr(8'h39, 8'h04);
    pix_check(99, 2, 6'h03, "R7 old position kept on drawn line");
    pix_check(99, 3, 6'h00, "R7 new position on next line");
    pix_check(115, 3, 6'h03, "R7 new position on next line");

    // R8: out-of-range requests clamp to X=4, Y=0
    wr(8'h39, 8'hFF); wr(8'h3A, 8'hFF);
    pix_check(35, 3, 6'h30, "R8 clamped X/Y");
    pix_check(27, 3, 6'h00, "R8 clamped X left edge");
    pix_check(123, 91, 6'h03, "R8 clamped sprite corner");

    // R11: write to unmapped address has no effect
    wr(8'h3F, 8'hFF);
    pix_check(27, 3, 6'h00, "R11 unmapped write ignored");
    pix_check(35, 3, 6'h30, "R11 unmapped write ignored");

    // R5: aborted half frame dropped, following frame aligned
    spi_send(8'h38, 8'h00, 8);
    wr(8'h38, 8'h01);
    pix_check(27, 3, 6'h15, "R5 frame after abort");

    // R1: sync position and width, fast mode
    sync_check(131, 5, 1'b0, 1'b0);
    sync_check(132, 5, 1'b1, 1'b0);
    sync_check(139, 5, 1'b1, 1'b0);
    sync_check(140, 5, 1'b0, 1'b0);
    sync_check(143, 96, 1'b0, 1'b0);
    sync_check(0, 97, 1'b0, 1'b1);
    sync_check(143, 98, 1'b0, 1'b1);
    sync_check(0, 99, 1'b0, 1'b0);

    // R10: reset mid-frame restarts raster and clears configuration
    wait_pix(60, 40);
    reset_pulse();
    sync_check(131, 0, 1'b0, 1'b0);
    sync_check(132, 0, 1'b1, 1'b0);
    pix_check(19, 3, 6'h00, "R10 configuration cleared");

    // R9: 10 MHz mode, four screen pixels per clock
    slow_pix = 1'b1;
    reset_pulse();
    do @(negedge clk); while (hsync);
    do @(negedge clk); while (!hsync);
    n = 0;
    do begin @(negedge clk); n++; end while (hsync);
    check(n == HS / 4, "R9 slow hsync width", n, HS / 4);
    while (!hsync) begin @(negedge clk); n++; end
    check(n == HT / 4, "R9 slow line length", n, HT / 4);
    do @(negedge clk); while (!vsync);
    n = 0;
    do begin @(negedge clk); n++; end while (vsync);
    check(n == VS * HT / 4, "R9 slow vsync width", n, VS * HT / 4);

    finish_up();
  end

endmodule